// File: doc/BRIEF.md
# Three-Channel Pixel Colour Lookup Table

This unit remaps a stream of pixels through three lookup tables. Each table has 256 entries, and each entry is 10 bits wide. Every pixel has 10-bit red, green and blue components and an 8-bit alpha. Only the top eight bits of a component form a table address.

In colour mode, each component is translated through its own table. In index mode, the red component alone selects one entry from every table, which gives palette-style expansion. In bypass mode, the pixel passes unchanged. Two further options are sampled together with each pixel:
- an alpha mask, which blanks the colour of fully transparent pixels;
- a low-bit keep option, which restores the two address-truncated input bits in colour mode.

Software fills and inspects the tables through a small register port. The pixel interface uses valid/ready with a fixed two-cycle latency. A table write that coincides with a pixel lookup is deferred by one cycle.

Top module: `tri_lut_pixel`

## Requirements
- R1: After reset `out_valid_o` is 0 and every table entry reads back as 0.
- R2: A register write with `reg_we_i` high while `reg_wready_o` is high stores `reg_wdata_i` into the table chosen by `reg_sel_i` (0 red, 1 green, 2 blue) at `reg_addr_i`. A read with `reg_re_i` returns that entry on `reg_rdata_o` one cycle later. `reg_sel_i`=3 selects no table and reads return 0.
- R3: With `mode_i`=2'b01 (colour), the outputs are red = T0[in_r[9:2]], green = T1[in_g[9:2]] and blue = T2[in_b[9:2]].
- R4: With `mode_i`=2'b10 (index), the outputs are T0, T1 and T2 all addressed by in_r[9:2]. The green and blue inputs have no effect.
- R5: With `mode_i`=2'b00 or 2'b11 (bypass), the output colour equals the input colour.
- R6: A pixel accepted at a clock edge appears on the outputs after the next edge. `in_ready_o` equals `out_ready_i` in the same cycle.
- R7: While `out_ready_i` is low, the output pixel and `out_valid_o` hold, and no input pixel is accepted.
- R8: Alpha passes through unchanged in every mode. When `mask_en_i` is 1 and alpha is 0, all three output colours are 0.
- R9: In colour mode with `lsb_en_i`=1, bits [1:0] of each output colour are taken from the same input component. Bits [9:2] still come from the table.
- R10: A write that meets a pixel lookup in the same cycle is held for one cycle, and `reg_wready_o` is low during that cycle. Lookups in both of those cycles see the old entry. A write made while the pipeline is stalled takes effect at once, and `reg_wready_o` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 2 | Operating mode: 0/3 bypass, 1 colour, 2 index |
| mask_en_i | input | 1 | Alpha mask enable |
| lsb_en_i | input | 1 | Keep input low bits in colour mode |
| in_valid_i | input | 1 | Input pixel valid |
| in_ready_o | output | 1 | Input pixel ready |
| in_r_i | input | 10 | Input red |
| in_g_i | input | 10 | Input green |
| in_b_i | input | 10 | Input blue |
| in_a_i | input | 8 | Input alpha |
| out_valid_o | output | 1 | Output pixel valid |
| out_ready_i | input | 1 | Output pixel ready |
| out_r_o | output | 10 | Output red |
| out_g_o | output | 10 | Output green |
| out_b_o | output | 10 | Output blue |
| out_a_o | output | 8 | Output alpha |
| reg_we_i | input | 1 | Table write request |
| reg_wready_o | output | 1 | Table write can be accepted |
| reg_re_i | input | 1 | Table read request |
| reg_sel_i | input | 2 | Table select |
| reg_addr_i | input | 8 | Table entry address |
| reg_wdata_i | input | 10 | Table write data |
| reg_rdata_o | output | 10 | Table read data |

## Verification
The embedded assertions check these properties on every cycle:
- the output holds steady under back-pressure;
- masked transparent pixels leave with zero colour;
- bypassed pixels come out unchanged;
- a deferred write is held for exactly one cycle and only after a pixel lookup.

The bench scenarios cover what depends on table contents: colour and index translation, low-bit keeping, and read-back through the register port. A timed streaming sequence shows that a write colliding with lookups stays invisible to the two pixels read in those cycles and reaches the third.

// File: rtl/clut_pkg.sv
package clut_pkg;
  parameter int unsigned CLUT_CW    = 10;
  parameter int unsigned CLUT_AW    = 8;
  parameter int unsigned CLUT_DEPTH = 256;
  parameter int unsigned CLUT_NT    = 3;

  typedef enum logic [1:0] {
    MODE_BYP  = 2'b00,
    MODE_COL  = 2'b01,
    MODE_IDX  = 2'b10,
    MODE_BYP2 = 2'b11
  } clut_mode_e;

  typedef struct packed {
    logic [CLUT_CW-1:0] r;
    logic [CLUT_CW-1:0] g;
    logic [CLUT_CW-1:0] b;
    logic [CLUT_AW-1:0] a;
  } clut_pix_t;
endpackage

// File: rtl/clut_table.sv
module clut_table #(
  parameter int unsigned DW    = 10,
  parameter int unsigned DEPTH = 256,
  localparam int unsigned IW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [IW-1:0] wr_addr_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic [IW-1:0] pix_addr_i,
  output logic [DW-1:0] pix_q_o,
  input  logic [IW-1:0] reg_addr_i,
  output logic [DW-1:0] reg_q_o
);
  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (wr_en_i) begin
      mem_q[wr_addr_i] <= wr_data_i;
    end
  end

  assign pix_q_o = mem_q[pix_addr_i];
  assign reg_q_o = mem_q[reg_addr_i];
endmodule

// File: rtl/clut_wr_arb.sv
module clut_wr_arb #(
  parameter int unsigned DW = 10,
  parameter int unsigned IW = 8,
  parameter int unsigned NT = 3,
  localparam int unsigned SW = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [SW-1:0] sel_i,
  input  logic [IW-1:0] addr_i,
  input  logic [DW-1:0] data_i,
  input  logic          pix_rd_i,
  output logic          wready_o,
  output logic [NT-1:0] wr_en_o,
  output logic [IW-1:0] wr_addr_o,
  output logic [DW-1:0] wr_data_o
);
  logic          pend_q;
  logic [SW-1:0] pend_sel_q;
  logic [IW-1:0] pend_addr_q;
  logic [DW-1:0] pend_data_q;
  logic          take;
  logic          defer;
  logic [SW-1:0] act_sel;

  assign wready_o = !pend_q;
  assign take     = we_i && !pend_q;
  assign defer    = take && pix_rd_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q      <= 1'b0;
      pend_sel_q  <= '0;
      pend_addr_q <= '0;
      pend_data_q <= '0;
    end else begin
      pend_q <= defer;
      if (defer) begin
        pend_sel_q  <= sel_i;
        pend_addr_q <= addr_i;
        pend_data_q <= data_i;
      end
    end
  end

  // pending write retires unconditionally; tables read the old value this cycle
  assign act_sel   = pend_q ? pend_sel_q : sel_i;
  assign wr_addr_o = pend_q ? pend_addr_q : addr_i;
  assign wr_data_o = pend_q ? pend_data_q : data_i;

  for (genvar t = 0; t < NT; t++) begin : g_en
    assign wr_en_o[t] = (pend_q || (take && !pix_rd_i)) && (act_sel == SW'(t));
  end

  assert_pend_one_cycle_R10 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_q |=> !pend_q);
  assert_pend_after_read_R10 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pend_q) |-> $past(pix_rd_i));
endmodule

// File: rtl/tri_lut_pixel.sv
module tri_lut_pixel
  import clut_pkg::*;
#(
  parameter int unsigned CW    = CLUT_CW,
  parameter int unsigned AW    = CLUT_AW,
  parameter int unsigned DEPTH = CLUT_DEPTH,
  localparam int unsigned IW   = $clog2(DEPTH),
  localparam int unsigned LW   = CW - IW,
  localparam int unsigned NT   = CLUT_NT
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [1:0]    mode_i,
  input  logic          mask_en_i,
  input  logic          lsb_en_i,
  input  logic          in_valid_i,
  output logic          in_ready_o,
  input  logic [CW-1:0] in_r_i,
  input  logic [CW-1:0] in_g_i,
  input  logic [CW-1:0] in_b_i,
  input  logic [AW-1:0] in_a_i,
  output logic          out_valid_o,
  input  logic          out_ready_i,
  output logic [CW-1:0] out_r_o,
  output logic [CW-1:0] out_g_o,
  output logic [CW-1:0] out_b_o,
  output logic [AW-1:0] out_a_o,
  input  logic          reg_we_i,
  output logic          reg_wready_o,
  input  logic          reg_re_i,
  input  logic [1:0]    reg_sel_i,
  input  logic [IW-1:0] reg_addr_i,
  input  logic [CW-1:0] reg_wdata_i,
  output logic [CW-1:0] reg_rdata_o
);
  logic          adv;
  logic          s1_valid_q, s2_valid_q;
  clut_pix_t     s1_pix_q, s2_pix_q, s2_pix_d;
  clut_mode_e    s1_mode_q;
  logic          s1_mask_q, s1_lsb_q;
  logic          s1_lookup;
  logic          pix_rd;

  logic [CW-1:0] comp    [NT];
  logic [CW-1:0] tbl_q   [NT];
  logic [CW-1:0] reg_q   [NT];
  logic [CW-1:0] mapped  [NT];
  logic [IW-1:0] tbl_addr[NT];

  logic [NT-1:0] wr_en;
  logic [IW-1:0] wr_addr;
  logic [CW-1:0] wr_data;

  assign adv        = out_ready_i;
  assign in_ready_o = out_ready_i;
  assign s1_lookup  = (s1_mode_q == MODE_COL) || (s1_mode_q == MODE_IDX);
  assign pix_rd     = adv && s1_valid_q && s1_lookup;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_valid_q <= 1'b0;
      s1_pix_q   <= '0;
      s1_mode_q  <= MODE_BYP;
      s1_mask_q  <= 1'b0;
      s1_lsb_q   <= 1'b0;
    end else if (adv) begin
      s1_valid_q <= in_valid_i;
      if (in_valid_i) begin
        s1_pix_q  <= '{r: in_r_i, g: in_g_i, b: in_b_i, a: in_a_i};
        s1_mode_q <= clut_mode_e'(mode_i);
        s1_mask_q <= mask_en_i;
        s1_lsb_q  <= lsb_en_i;
      end
    end
  end

  assign comp[0] = s1_pix_q.r;
  assign comp[1] = s1_pix_q.g;
  assign comp[2] = s1_pix_q.b;

  for (genvar t = 0; t < NT; t++) begin : g_tbl
    assign tbl_addr[t] = (s1_mode_q == MODE_IDX) ? comp[0][CW-1 -: IW] : comp[t][CW-1 -: IW];

    clut_table #(.DW(CW), .DEPTH(DEPTH)) i_table (
      .clk_i,
      .rst_ni,
      .wr_en_i   (wr_en[t]),
      .wr_addr_i (wr_addr),
      .wr_data_i (wr_data),
      .pix_addr_i(tbl_addr[t]),
      .pix_q_o   (tbl_q[t]),
      .reg_addr_i(reg_addr_i),
      .reg_q_o   (reg_q[t])
    );

    always_comb begin
      unique case (s1_mode_q)
        MODE_COL: begin
          mapped[t] = tbl_q[t];
          if (s1_lsb_q) mapped[t][LW-1:0] = comp[t][LW-1:0];
        end
        MODE_IDX: mapped[t] = tbl_q[t];
        default:  mapped[t] = comp[t];
      endcase
      if (s1_mask_q && (s1_pix_q.a == '0)) mapped[t] = '0;
    end
  end

  assign s2_pix_d = '{r: mapped[0], g: mapped[1], b: mapped[2], a: s1_pix_q.a};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s2_valid_q <= 1'b0;
      s2_pix_q   <= '0;
    end else if (adv) begin
      s2_valid_q <= s1_valid_q;
      if (s1_valid_q) s2_pix_q <= s2_pix_d;
    end
  end

  assign out_valid_o = s2_valid_q;
  assign out_r_o     = s2_pix_q.r;
  assign out_g_o     = s2_pix_q.g;
  assign out_b_o     = s2_pix_q.b;
  assign out_a_o     = s2_pix_q.a;

  clut_wr_arb #(.DW(CW), .IW(IW), .NT(NT)) i_wr_arb (
    .clk_i,
    .rst_ni,
    .we_i     (reg_we_i),
    .sel_i    (reg_sel_i),
    .addr_i   (reg_addr_i),
    .data_i   (reg_wdata_i),
    .pix_rd_i (pix_rd),
    .wready_o (reg_wready_o),
    .wr_en_o  (wr_en),
    .wr_addr_o(wr_addr),
    .wr_data_o(wr_data)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      reg_rdata_o <= '0;
    end else if (reg_re_i) begin
      reg_rdata_o <= (reg_sel_i < 2'(NT)) ? reg_q[reg_sel_i] : '0;
    end
  end

  assert_stall_hold_R7 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!out_ready_i && out_valid_o) |=> (out_valid_o && $stable(out_r_o) && $stable(out_g_o)
                                       && $stable(out_b_o) && $stable(out_a_o)));
  assert_mask_zero_R8 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv && s1_valid_q && s1_mask_q && s1_pix_q.a == '0) |=>
      (out_valid_o && out_r_o == '0 && out_g_o == '0 && out_b_o == '0 && out_a_o == '0));
  assert_bypass_pass_R5 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv && s1_valid_q && !s1_lookup && !s1_mask_q) |=>
      (out_r_o == $past(s1_pix_q.r) && out_g_o == $past(s1_pix_q.g)
       && out_b_o == $past(s1_pix_q.b) && out_a_o == $past(s1_pix_q.a)));
endmodule

// File: tb/test_tri_lut_pixel.sv
module test_tri_lut_pixel;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] mode = '0;
  logic       mask_en = 1'b0, lsb_en = 1'b0;
  logic       in_valid = 1'b0, out_ready = 1'b1;
  logic [9:0] in_r = '0, in_g = '0, in_b = '0;
  logic [7:0] in_a = '0;
  logic       in_ready, out_valid, reg_wready;
  logic [9:0] out_r, out_g, out_b, reg_rdata;
  logic [7:0] out_a;
  logic       reg_we = 1'b0, reg_re = 1'b0;
  logic [1:0] reg_sel = '0;
  logic [7:0] reg_addr = '0;
  logic [9:0] reg_wdata = '0;

  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  tri_lut_pixel i_tri_lut_pixel (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .mask_en_i(mask_en), .lsb_en_i(lsb_en),
    .in_valid_i(in_valid), .in_ready_o(in_ready), .in_r_i(in_r), .in_g_i(in_g),
    .in_b_i(in_b), .in_a_i(in_a), .out_valid_o(out_valid), .out_ready_i(out_ready),
    .out_r_o(out_r), .out_g_o(out_g), .out_b_o(out_b), .out_a_o(out_a),
    .reg_we_i(reg_we), .reg_wready_o(reg_wready), .reg_re_i(reg_re), .reg_sel_i(reg_sel),
    .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata)
  );

  function automatic logic [9:0] tval(int t, int i);
    return 10'((i * 37 + t * 211 + 5) % 1024);
  endfunction

  task automatic chk(string req, logic [47:0] act, logic [47:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] s, logic [7:0] a, logic [9:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_sel = s; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(logic [1:0] s, logic [7:0] a, output logic [9:0] d);
    @(negedge clk);
    reg_re = 1'b1; reg_sel = s; reg_addr = a;
    @(negedge clk);
    reg_re = 1'b0;
    d = reg_rdata;
  endtask

  // mode(2) mask(1) lsb(1) r g b (10 each) a(8) = 42 bits
  localparam int NV = 10;
  localparam logic [NV-1:0][41:0] VEC = '{
    {2'b01, 1'b0, 1'b0, 10'd0,   10'd4,   10'd8,   8'd255},
    {2'b01, 1'b0, 1'b0, 10'd1023,10'd512, 10'd3,   8'd17},
    {2'b01, 1'b0, 1'b1, 10'd403, 10'd602, 10'd801, 8'd9},
    {2'b10, 1'b0, 1'b0, 10'd84,  10'd999, 10'd1,   8'd40},
    {2'b10, 1'b0, 1'b0, 10'd87,  10'd0,   10'd777, 8'd41},
    {2'b00, 1'b0, 1'b0, 10'd321, 10'd654, 10'd987, 8'd3},
    {2'b11, 1'b0, 1'b1, 10'd15,  10'd16,  10'd17,  8'd0},
    {2'b01, 1'b1, 1'b0, 10'd200, 10'd300, 10'd400, 8'd0},
    {2'b01, 1'b1, 1'b0, 10'd200, 10'd300, 10'd400, 8'd1},
    {2'b10, 1'b0, 1'b0, 10'd500, 10'd6,   10'd7,   8'd0}
  };

  function automatic logic [37:0] model(logic [41:0] v);
    logic [1:0] m = v[41:40];
    logic mk = v[39], lb = v[38];
    logic [9:0] r = v[37:28], g = v[27:18], b = v[17:8];
    logic [7:0] a = v[7:0];
    logic [9:0] orr, og, ob;
    if (m == 2'b01) begin
      orr = tval(0, int'(r[9:2])); og = tval(1, int'(g[9:2])); ob = tval(2, int'(b[9:2]));
      if (lb) begin orr[1:0] = r[1:0]; og[1:0] = g[1:0]; ob[1:0] = b[1:0]; end
    end else if (m == 2'b10) begin
      orr = tval(0, int'(r[9:2])); og = tval(1, int'(r[9:2])); ob = tval(2, int'(r[9:2]));
    end else begin
      orr = r; og = g; ob = b;
    end
    if (mk && a == 8'd0) begin orr = '0; og = '0; ob = '0; end
    return {orr, og, ob, a};
  endfunction

  task automatic drive(logic [41:0] v);
    mode = v[41:40]; mask_en = v[39]; lsb_en = v[38];
    in_r = v[37:28]; in_g = v[27:18]; in_b = v[17:8]; in_a = v[7:0];
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [9:0] d;
    repeat (3) @(negedge clk);
    chk("R1 out_valid after reset", 48'(out_valid), 48'(0));
    rst_n = 1'b1;
    rd(2'd1, 8'd5, d);
    chk("R1 table entry after reset", 48'(d), 48'(0));

    for (int t = 0; t < 3; t++)
      for (int i = 0; i < 256; i++) wr(2'(t), 8'(i), tval(t, i));
    rd(2'd2, 8'd77, d);
    chk("R2 readback blue", 48'(d), 48'(tval(2, 77)));
    rd(2'd0, 8'd255, d);
    chk("R2 readback red", 48'(d), 48'(tval(0, 255)));
    rd(2'd3, 8'd10, d);
    chk("R2 sel 3 reads zero", 48'(d), 48'(0));

    // vector walk: R3 R4 R5 R8 R9 and R6 latency
    for (int k = 0; k < NV; k++) begin
      @(negedge clk);
      drive(VEC[k]); in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      chk("R6 not yet valid", 48'(out_valid), 48'(0));
      @(negedge clk);
      chk("R6 valid after two edges", 48'(out_valid), 48'(1));
      chk("R3 R4 R5 R8 R9 pixel", 48'({out_r, out_g, out_b, out_a}), 48'(model(VEC[k])));
    end

    // R7 stall
    @(negedge clk);
    drive(VEC[0]); in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    @(negedge clk);
    out_ready = 1'b0; drive(VEC[5]); in_valid = 1'b1;
    #1;
    chk("R6 in_ready follows out_ready", 48'(in_ready), 48'(0));
    repeat (3) @(negedge clk);
    chk("R7 held valid", 48'(out_valid), 48'(1));
    chk("R7 held pixel", 48'({out_r, out_g, out_b, out_a}), 48'(model(VEC[0])));
    in_valid = 1'b0; out_ready = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk("R7 stalled input not accepted", 48'(out_valid), 48'(0));

    // R10 deferred write during streaming
    @(negedge clk);
    drive({2'b01, 1'b0, 1'b0, 10'd40, 10'd0, 10'd0, 8'd5}); in_valid = 1'b1;
    @(negedge clk);
    reg_we = 1'b1; reg_sel = 2'd0; reg_addr = 8'd10; reg_wdata = 10'h2AA;
    @(negedge clk);
    reg_we = 1'b0;
    chk("R10 first pixel old entry", 48'(out_r), 48'(tval(0, 10)));
    chk("R10 wready low while pending", 48'(reg_wready), 48'(0));
    @(negedge clk);
    in_valid = 1'b0;
    chk("R10 second pixel old entry", 48'(out_r), 48'(tval(0, 10)));
    chk("R10 wready back", 48'(reg_wready), 48'(1));
    @(negedge clk);
    chk("R10 third pixel new entry", 48'(out_r), 48'(10'h2AA));

    // R10 write while stalled takes effect at once
    @(negedge clk);
    out_ready = 1'b0;
    wr(2'd1, 8'd20, 10'h155);
    chk("R10 stalled write no defer", 48'(reg_wready), 48'(1));
    rd(2'd1, 8'd20, d);
    chk("R2 R10 stalled write stored", 48'(d), 48'(10'h155));
    out_ready = 1'b1;

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule